// File: doc/BRIEF.md
# SD card clock divider

This block derives the SD card bus clock from the peripheral clock. A requested integer divisor is converted into a one-hot power-of-two prescaler field and a 4-bit divider field, and the conversion always rounds so that the card clock is never faster than requested. The resulting total ratio drives a single period counter that produces a registered card clock level. A one-cycle card tick marks each card clock rising edge inside the peripheral clock domain.

A settings load is staged and takes effect only at the end of a card clock period, or at once while the clock is gated off, so no shortened pulse reaches the card. Each applied change clears a stability flag, and the flag sets again after a fixed number of peripheral clocks. The gate opens only while the flag is set, and opening the gate clears the flag again. Two helpers count card clock edges. The first is an initialisation burst of 80 idle card cycles, shown by a busy flag. The second is a data-timeout counter whose terminal count is a power of two chosen by a 4-bit field.

Top module: `sd_clk_gen`

## Requirements
- R1: After reset the card clock is low, both setting fields read zero, the init busy and timeout flags are low, and the stable flag is low for the first three peripheral cycles after reset release and high from the fourth.
- R2: With prescaler field P (one-hot, bit k set gives a factor of 2^(k+1), zero gives 1) and divider field D, the card clock period is N = factor*(D+1) peripheral cycles: high for ceil(N/2) cycles and low for the rest. When N is 1 the clock level stays high while running.
- R3: A requested divisor of 0 or 1 yields prescaler 0 and divider 0.
- R4: An odd divisor from 3 to 15 yields prescaler 0 and divider equal to the divisor minus 1.
- R5: An even divisor from 2 to 32 yields prescaler 1 (bit 0) and divider equal to half the divisor minus 1.
- R6: A divisor of 4096 or more yields prescaler 0x80 and divider 15.
- R7: Any other divisor is shifted right by the least amount that leaves a 4-bit value. The divider is that value minus 1, or the value itself when nonzero bits were dropped. The prescaler has bit (shift-1) set. The resulting ratio is never below the request.
- R8: In the cycle new settings appear on the field outputs the stable flag is low, and it is high again exactly four cycles later. The clock gate opens only from a cycle with the flag high, and opening it clears the flag.
- R9: With the enable low the clock stops at the end of its current period and stays low. A load made while stopped appears on the field outputs within two cycles without any clock edge. When the enable returns, the clock restarts.
- R10: An init request raises the busy flag, which stays high for 80 card clock rising edges and then clears by itself.
- R11: With the timeout run input held high, the timeout flag sets after 2^(sel+13) card clock rising edges, where sel is the 4-bit field loaded with the settings. Dropping the run input clears the flag and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| cfgLoad | input | 1 | Strobe: load the divisor and timeout select |
| reqDiv | input | 16 | Requested integer divisor |
| toutSel | input | 4 | Timeout exponent select |
| clkEn | input | 1 | Card clock enable |
| initReq | input | 1 | Strobe: start the 80-cycle idle burst |
| toutRun | input | 1 | High while waiting on a data phase |
| sdClk | output | 1 | Card clock level |
| clkStable | output | 1 | Divider settled flag |
| curPresc | output | 8 | Applied one-hot prescaler field |
| curDvs | output | 4 | Applied divider field |
| initBusy | output | 1 | Idle burst in progress |
| toutHit | output | 1 | Data timeout reached |

## Verification
Divisors are chosen from each mapping branch: pass-through values 0 and 1, small odd values, even values up to 32, the saturation point 4096, and large odd and even values that force a shift with and without dropped bits. Matching fields alone would hide a wrong ratio formula, so each load is also checked by measuring the high and low lengths of a full card clock period. The stable-flag delay is counted after every load. Gating is tried both mid-run and with a load made while the clock is stopped, which separates deferred application from immediate application. The init burst and timeout are checked by counting observed card clock edges, and the timeout uses a nonzero select so that its exponent offset is distinguished.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  parameter int PRE_W = 8;
  parameter int DVS_W = 4;
  localparam int RATIO_W = PRE_W + DVS_W + 1;

  typedef struct packed {
    logic run;        // card clock gate open
    logic restart;    // restart the period counter
    logic initStart;  // load the idle burst counter
  } clkStrb_t;

  // total ratio of a prescaler/divider pair
  function automatic logic [RATIO_W-1:0] ratioOf(logic [PRE_W-1:0] p, logic [DVS_W-1:0] d);
    logic [RATIO_W-1:0] r;
    int sh;
    sh = 0;
    for (int k = 0; k < PRE_W; k++) begin
      if (p[k]) sh = k + 1;
    end
    r = RATIO_W'(d) + RATIO_W'(1);
    return r << sh;
  endfunction
endpackage

// File: rtl/sdclk_divmap.sv
module sdclk_divmap
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic [DIV_W-1:0] reqDiv,
  output logic [PRE_W-1:0] mapPresc,
  output logic [DVS_W-1:0] mapDvs
);
  localparam int ODD_MAX  = 1 << DVS_W;
  localparam int EVEN_MAX = 2 * ODD_MAX;
  localparam int SAT_MIN  = 1 << (PRE_W + DVS_W);

  int msb;
  int sh;
  logic [DIV_W-1:0] topBits;
  logic [DIV_W-1:0] dropBits;

  always_comb begin
    mapPresc = '0;
    mapDvs   = '0;
    topBits  = '0;
    dropBits = '0;
    msb = 0;
    for (int i = 0; i < DIV_W; i++) begin
      if (reqDiv[i]) msb = i;
    end
    sh = msb - (DVS_W - 1);
    if (reqDiv <= DIV_W'(1)) begin
      mapPresc = '0;
      mapDvs   = '0;
    end else if (reqDiv <= DIV_W'(ODD_MAX) && reqDiv[0]) begin
      mapDvs = DVS_W'(reqDiv - DIV_W'(1));
    end else if (reqDiv <= DIV_W'(EVEN_MAX) && !reqDiv[0]) begin
      mapPresc = PRE_W'(1);
      mapDvs   = DVS_W'((reqDiv >> 1) - DIV_W'(1));
    end else if (reqDiv >= DIV_W'(SAT_MIN)) begin
      mapPresc = PRE_W'(1) << (PRE_W - 1);
      mapDvs   = '1;
    end else begin
      topBits  = reqDiv >> sh;
      dropBits = reqDiv & DIV_W'((1 << sh) - 1);
      mapDvs   = DVS_W'(topBits - ((dropBits != '0) ? DIV_W'(0) : DIV_W'(1)));
      mapPresc = PRE_W'(1) << (sh - 1);
    end
  end
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int STB_DLY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgLoad,
  input  logic [PRE_W-1:0]   mapPresc,
  input  logic [DVS_W-1:0]   mapDvs,
  input  logic [SEL_W-1:0]   selIn,
  input  logic               clkEn,
  input  logic               initReq,
  input  logic               initBusy,
  input  logic               periodEnd,
  output clkStrb_t           strb,
  output logic [PRE_W-1:0]   actPresc,
  output logic [DVS_W-1:0]   actDvs,
  output logic [SEL_W-1:0]   actSel,
  output logic [RATIO_W-1:0] ratio,
  output logic [RATIO_W-1:0] hiLen,
  output logic               stable
);
  localparam int STB_W = $clog2(STB_DLY + 1);

  logic             pendValid;
  logic [PRE_W-1:0] pendPresc;
  logic [DVS_W-1:0] pendDvs;
  logic [SEL_W-1:0] pendSel;
  logic             running;
  logic [STB_W-1:0] stbCnt;
  logic             applyNow;
  logic             gateOn;
  logic             gateOff;

  assign stable   = (stbCnt == STB_W'(STB_DLY));
  assign applyNow = pendValid && (!running || periodEnd);
  assign gateOn   = !running && !pendValid && clkEn && stable;
  assign gateOff  = running && !clkEn && periodEnd;
  assign ratio    = ratioOf(actPresc, actDvs);
  assign hiLen    = (ratio + RATIO_W'(1)) >> 1;

  assign strb.run       = running;
  assign strb.restart   = applyNow || gateOn;
  assign strb.initStart = initReq && !initBusy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendValid <= 1'b0;
      pendPresc <= '0;
      pendDvs   <= '0;
      pendSel   <= '0;
      actPresc  <= '0;
      actDvs    <= '0;
      actSel    <= '0;
      running   <= 1'b0;
      stbCnt    <= '0;
    end else begin
      if (applyNow) begin
        actPresc <= pendPresc;
        actDvs   <= pendDvs;
        actSel   <= pendSel;
        running  <= 1'b0;
        stbCnt   <= '0;
      end else if (gateOn) begin
        running <= 1'b1;
        stbCnt  <= '0;
      end else begin
        if (gateOff) running <= 1'b0;
        if (!stable) stbCnt <= stbCnt + STB_W'(1);
      end
      if (cfgLoad) begin
        pendValid <= 1'b1;
        pendPresc <= mapPresc;
        pendDvs   <= mapDvs;
        pendSel   <= selIn;
      end else if (applyNow) begin
        pendValid <= 1'b0;
      end
    end
  end

  AST_STB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (applyNow || gateOn) |=> !stable) else $error("stable not cleared on change"); // R8
  AST_RUN_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(stable)) else $error("gate opened before settling"); // R8
  AST_PRESC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(actPresc)) else $error("prescaler field not one-hot"); // R2
endmodule

// File: rtl/sdclk_datapath.sv
module sdclk_datapath
  import sdclk_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter int TOUT_BASE   = 13,
  parameter int INIT_CYCLES = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  clkStrb_t           strb,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [RATIO_W-1:0] hiLen,
  input  logic [SEL_W-1:0]   toutSel,
  input  logic               toutRun,
  output logic               sdClk,
  output logic               periodEnd,
  output logic               initBusy,
  output logic               toutHit
);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam int TOUT_W = TOUT_BASE + (1 << SEL_W);

  logic [RATIO_W-1:0] cnt;
  logic [INIT_W-1:0]  initLeft;
  logic [TOUT_W-1:0]  toutCnt;
  logic [TOUT_W-1:0]  toutLimit;
  logic               tick;
  logic               lastPhase;

  assign lastPhase = (cnt == ratio - RATIO_W'(1));
  assign tick      = strb.run && (cnt == '0);
  assign periodEnd = strb.run && lastPhase;
  assign initBusy  = (initLeft != '0);
  assign toutLimit = TOUT_W'(1) << (TOUT_BASE + int'(toutSel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sdClk <= 1'b0;
    end else begin
      if (!strb.run || strb.restart || lastPhase) cnt <= '0;
      else cnt <= cnt + RATIO_W'(1);
      sdClk <= strb.run && (cnt < hiLen);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initLeft <= '0;
    end else if (strb.initStart) begin
      initLeft <= INIT_W'(INIT_CYCLES);
    end else if (tick && initBusy) begin
      initLeft <= initLeft - INIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toutCnt <= '0;
      toutHit <= 1'b0;
    end else if (!toutRun) begin
      toutCnt <= '0;
      toutHit <= 1'b0;
    end else if (tick && !toutHit) begin
      toutCnt <= toutCnt + TOUT_W'(1);
      if (toutCnt + TOUT_W'(1) == toutLimit) toutHit <= 1'b1;
    end
  end

  AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.run |=> !sdClk) else $error("clock active while gated"); // R9
  AST_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (periodEnd && ratio > RATIO_W'(1)) |=> !sdClk) else $error("period does not end low"); // R2
  AST_INIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    initLeft <= INIT_W'(INIT_CYCLES)) else $error("idle burst count overrun"); // R10
  AST_TOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (toutHit && toutRun) |=> toutHit) else $error("timeout flag dropped"); // R11
endmodule

// File: rtl/sd_clk_gen.sv
module sd_clk_gen
  import sdclk_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SEL_W       = 4,
  parameter int TOUT_BASE   = 13,
  parameter int STB_DLY     = 4,
  parameter int INIT_CYCLES = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgLoad,
  input  logic [DIV_W-1:0] reqDiv,
  input  logic [SEL_W-1:0] toutSel,
  input  logic             clkEn,
  input  logic             initReq,
  input  logic             toutRun,
  output logic             sdClk,
  output logic             clkStable,
  output logic [PRE_W-1:0] curPresc,
  output logic [DVS_W-1:0] curDvs,
  output logic             initBusy,
  output logic             toutHit
);
  localparam int SAT_MIN = 1 << (PRE_W + DVS_W);

  clkStrb_t           strb;
  logic [PRE_W-1:0]   mapPresc;
  logic [DVS_W-1:0]   mapDvs;
  logic [SEL_W-1:0]   actSel;
  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] hiLen;
  logic               periodEnd;

  sdclk_divmap #(.DIV_W(DIV_W)) u_map (
    .reqDiv(reqDiv), .mapPresc(mapPresc), .mapDvs(mapDvs)
  );

  sdclk_ctrl #(.SEL_W(SEL_W), .STB_DLY(STB_DLY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgLoad(cfgLoad),
    .mapPresc(mapPresc), .mapDvs(mapDvs), .selIn(toutSel),
    .clkEn(clkEn), .initReq(initReq), .initBusy(initBusy),
    .periodEnd(periodEnd), .strb(strb),
    .actPresc(curPresc), .actDvs(curDvs), .actSel(actSel),
    .ratio(ratio), .hiLen(hiLen), .stable(clkStable)
  );

  sdclk_datapath #(.SEL_W(SEL_W), .TOUT_BASE(TOUT_BASE), .INIT_CYCLES(INIT_CYCLES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .ratio(ratio), .hiLen(hiLen),
    .toutSel(actSel), .toutRun(toutRun), .sdClk(sdClk),
    .periodEnd(periodEnd), .initBusy(initBusy), .toutHit(toutHit)
  );

  AST_ROUND_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgLoad && int'(reqDiv) <= SAT_MIN) |-> int'(ratioOf(mapPresc, mapDvs)) >= int'(reqDiv))
    else $error("mapped ratio below request"); // R7
endmodule

// File: tb/tb_sd_clk_gen.sv
module tb_sd_clk_gen;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        cfgLoad;
  logic [15:0] reqDiv;
  logic [3:0]  toutSel;
  logic        clkEn;
  logic        initReq;
  logic        toutRun;
  logic        sdClk;
  logic        clkStable;
  logic [7:0]  curPresc;
  logic [3:0]  curDvs;
  logic        initBusy;
  logic        toutHit;

  sd_clk_gen dut (
    .clk(clk), .rst_n(rst_n), .cfgLoad(cfgLoad), .reqDiv(reqDiv),
    .toutSel(toutSel), .clkEn(clkEn), .initReq(initReq), .toutRun(toutRun),
    .sdClk(sdClk), .clkStable(clkStable), .curPresc(curPresc), .curDvs(curDvs),
    .initBusy(initBusy), .toutHit(toutHit)
  );

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    int    div;
    int    presc;
    int    dvs;
    int    ratio;
    string tag;
  } expItem_t;

  expItem_t sbq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic expItem_t model(input int d);
    expItem_t e;
    int s;
    e.div = d;
    if (d <= 1) begin
      e.presc = 0; e.dvs = 0; e.tag = "R3";
    end else if (d <= 16 && (d % 2) == 1) begin
      e.presc = 0; e.dvs = d - 1; e.tag = "R4";
    end else if (d <= 32 && (d % 2) == 0) begin
      e.presc = 1; e.dvs = d / 2 - 1; e.tag = "R5";
    end else if (d >= 4096) begin
      e.presc = 128; e.dvs = 15; e.tag = "R6";
    end else begin
      s = 0;
      while ((d >> s) > 15) s++;
      e.dvs = (d >> s) - (((d % (1 << s)) != 0) ? 0 : 1);
      e.presc = 1 << (s - 1);
      e.tag = "R7";
    end
    e.ratio = ((e.presc == 0) ? 1 : 2 * e.presc) * (e.dvs + 1);
    return e;
  endfunction

  // monitor: consumes one expected item per load
  task automatic runItem(input expItem_t e);
    int guard;
    int n;
    int h;
    int l;
    bit prev;
    guard = 0;
    while (!(int'(curPresc) == e.presc && int'(curDvs) == e.dvs) && guard < 10000) begin
      @(negedge clk); guard++;
    end
    check(int'(curPresc) == e.presc, e.tag, int'(curPresc), e.presc, "prescaler field");
    check(int'(curDvs) == e.dvs, e.tag, int'(curDvs), e.dvs, "divider field");
    if (e.tag == "R7") check(e.ratio >= e.div, "R7", e.ratio, e.div, "ratio not below request");
    check(clkStable == 1'b0, "R8", int'(clkStable), 0, "stable low on apply");
    n = 0;
    while (!clkStable && n < 100) begin @(negedge clk); n++; end
    check(n == 4, "R8", n, 4, "cycles to stable");
    if (e.ratio == 1) begin
      repeat (20) @(negedge clk);
      h = 0;
      repeat (8) begin if (sdClk) h++; @(negedge clk); end
      check(h == 8, "R2", h, 8, "pass-through level high");
    end else begin
      prev = sdClk;
      guard = 0;
      while (!(!prev && sdClk) && guard < 20000) begin
        prev = sdClk; @(negedge clk); guard++;
      end
      h = 0;
      while (sdClk && h < 5000) begin h++; @(negedge clk); end
      l = 0;
      while (!sdClk && l < 5000) begin l++; @(negedge clk); end
      check(h == (e.ratio + 1) / 2, "R2", h, (e.ratio + 1) / 2, $sformatf("high length div=%0d", e.div));
      check(l == e.ratio - (e.ratio + 1) / 2, "R2", l, e.ratio - (e.ratio + 1) / 2,
            $sformatf("low length div=%0d", e.div));
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() != 0) begin
        runItem(sbq[0]);
        void'(sbq.pop_front());
      end
    end
  end

  // driver: pushes the expectation, then issues the load
  task automatic loadDiv(input int d, input int sel);
    sbq.push_back(model(d));
    @(negedge clk);
    reqDiv  = 16'(d);
    toutSel = 4'(sel);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog all-R actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int edges;
    int guard;
    bit prev;
    rst_n = 1'b0; cfgLoad = 1'b0; reqDiv = '0; toutSel = '0;
    clkEn = 1'b0; initReq = 1'b0; toutRun = 1'b0;
    repeat (3) @(negedge clk);
    check(sdClk == 1'b0, "R1", int'(sdClk), 0, "reset clock level");
    check(curPresc == 8'd0, "R1", int'(curPresc), 0, "reset prescaler");
    check(curDvs == 4'd0, "R1", int'(curDvs), 0, "reset divider");
    check(initBusy == 1'b0, "R1", int'(initBusy), 0, "reset init busy");
    check(toutHit == 1'b0, "R1", int'(toutHit), 0, "reset timeout");
    rst_n = 1'b1;
    @(negedge clk);
    check(clkStable == 1'b0, "R1", int'(clkStable), 0, "stable low after release");
    repeat (3) @(negedge clk);
    check(clkStable == 1'b1, "R1", int'(clkStable), 1, "stable after four cycles");
    check(sdClk == 1'b0, "R9", int'(sdClk), 0, "no clock while disabled");
    clkEn = 1'b1;
    repeat (10) @(negedge clk);

    loadDiv(7, 0);
    loadDiv(13, 0);
    loadDiv(16, 0);
    loadDiv(2, 0);
    loadDiv(32, 0);
    loadDiv(1, 0);
    loadDiv(17, 0);
    loadDiv(100, 0);
    loadDiv(64, 0);
    loadDiv(33, 0);
    loadDiv(4096, 0);
    loadDiv(1000, 0);
    loadDiv(0, 0);
    loadDiv(3, 0);
    loadDiv(8, 0);

    // R9: gating mid-run, then a load while stopped
    clkEn = 1'b0;
    repeat (20) @(negedge clk);
    edges = 0; prev = sdClk;
    repeat (50) begin
      @(negedge clk);
      if (sdClk) edges++;
      prev = sdClk;
    end
    check(edges == 0, "R9", edges, 0, "clock held low while disabled");
    reqDiv = 16'd9; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    edges = 0;
    repeat (2) begin @(negedge clk); if (sdClk) edges++; end
    check(int'(curDvs) == 8, "R9", int'(curDvs), 8, "divider applied while stopped");
    check(int'(curPresc) == 0, "R9", int'(curPresc), 0, "prescaler applied while stopped");
    check(edges == 0, "R9", edges, 0, "no pulse on stopped load");
    clkEn = 1'b1;
    edges = 0; prev = sdClk;
    repeat (60) begin
      @(negedge clk);
      if (!prev && sdClk) edges++;
      prev = sdClk;
    end
    check(edges >= 5, "R9", edges, 5, "clock resumes after enable");

    // R10: idle burst
    loadDiv(4, 0);
    initReq = 1'b1;
    @(negedge clk);
    initReq = 1'b0;
    check(initBusy == 1'b1, "R10", int'(initBusy), 1, "busy after request");
    edges = 0; guard = 0; prev = sdClk;
    while (initBusy && guard < 2000) begin
      @(negedge clk);
      if (!prev && sdClk) edges++;
      prev = sdClk;
      guard++;
    end
    check(edges >= 80 && edges <= 81, "R10", edges, 80, "edges during idle burst");

    // R11: timeout with select 1
    loadDiv(2, 1);
    toutRun = 1'b1;
    edges = 0; guard = 0; prev = sdClk;
    while (!toutHit && guard < 40000) begin
      @(negedge clk);
      if (!prev && sdClk) edges++;
      prev = sdClk;
      guard++;
    end
    check(toutHit == 1'b1, "R11", int'(toutHit), 1, "timeout reached");
    check(edges >= 16384 && edges <= 16385, "R11", edges, 16384, "edges to timeout");
    toutRun = 1'b0;
    @(negedge clk);
    check(toutHit == 1'b0, "R11", int'(toutHit), 0, "timeout cleared by run low");

    finishRun();
  end
endmodule